// File: doc/BRIEF.md
# Timer Capture Unit with Edge Prescaler

The unit watches an asynchronous input pin and, when a chosen event occurs there, stores the current value of a free-running timer in a holding register. The pin passes through a two-flop synchronizer, and an edge detector follows it. A 4-bit mode input selects the event: falling edges, rising edges, or every 4th or every 16th rising edge. Each capture raises a sticky flag, which stays set until a clear strobe arrives. Software reads the stored value before the next capture overwrites it.

The timer itself is outside the unit and arrives on `tmr_i`. The interrupt controller and the register mapping are also outside the unit. The off code resets the unit. A change of mode restarts the edge prescale count, so a mode switch never finishes a count that was begun under the old setting.

Top module: `tmr_snap`

## Requirements
- R1: While `mode_i` is 0000 (off), every clock edge clears `cap_o` to 0, clears `flag_o` and restarts the edge prescale count. An event already in flight is discarded.
- R2: The pin passes through two synchronizer flops. After a qualifying pin level change, the first clock edge that samples the new level is edge 1. `cap_o` takes the `tmr_i` value present at edge 4, and `flag_o` rises at that same edge.
- R3: Mode 0100 captures on every falling edge of the pin. Mode 0101 captures on every rising edge.
- R4: Mode 0110 captures on every 4th rising edge. Mode 0111 captures on every 16th rising edge. Counting starts from the last mode change or off period.
- R5: A new capture overwrites `cap_o` even when the earlier value was never read. Between captures, `cap_o` holds its value.
- R6: `flag_o` stays set after a capture until a clear strobe arrives. If no strobe arrives, it stays set.
- R7: When `flag_clr_i` is high at an edge with no capture, `flag_o` clears at that edge. If a capture occurs at the same edge, the capture wins and `flag_o` is 1.
- R8: At any edge where `mode_i` differs from its value at the previous edge, the prescale count restarts. A pin edge seen at that same clock does not produce a capture.
- R9: Mode codes 0001–0011 and 1xxx capture nothing. Under them, `cap_o` holds its value, and `flag_o` changes only through the clear strobe.
- R10: After asynchronous reset, `cap_o` is 0 and `flag_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 1 | Asynchronous capture pin |
| tmr_i | input | 16 | Free-running timer value |
| mode_i | input | 4 | Event select / off code |
| flag_clr_i | input | 1 | Clears the capture flag |
| cap_o | output | 16 | Captured timer value |
| flag_o | output | 1 | Sticky capture flag |

## Verification
A wrong prescale count shows as a capture on the wrong rising edge: one edge early or late under divide-by-4, and up to 15 edges off under divide-by-16. The bench sends long pulse trains and compares `cap_o` and `flag_o` against a reference model on every clock, so such an error appears within one prescale period. A synchronizer depth or latency error shifts the captured timer value. Because the timer input advances every cycle, this shows up at the very first capture. A stale pending event across an off period or a mode change would show as a flag rising when no event should occur, one cycle after the switch.

// File: rtl/snap_pkg.sv
package snap_pkg;
  localparam int unsigned MODE_W = 4;
  typedef enum logic [MODE_W-1:0] {
    MD_OFF   = 4'b0000,
    MD_FALL  = 4'b0100,
    MD_RISE  = 4'b0101,
    MD_RISE4 = 4'b0110,
    MD_RISE16= 4'b0111
  } snap_mode_e;
endpackage

// File: rtl/snap_edge.sv
module snap_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic [SYNC_STAGES:0] pipe_q;

  for (genvar g = 0; g <= SYNC_STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) pipe_q[0] <= 1'b0;
        else         pipe_q[0] <= pin_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) pipe_q[g] <= 1'b0;
        else         pipe_q[g] <= pipe_q[g-1];
    end
  end

  // last stage holds the previous synchronized level
  assign rise_o =  pipe_q[SYNC_STAGES-1] & ~pipe_q[SYNC_STAGES];
  assign fall_o = ~pipe_q[SYNC_STAGES-1] &  pipe_q[SYNC_STAGES];
endmodule

// File: rtl/snap_div.sv
module snap_div #(
  parameter int unsigned DIV_A = 4,
  parameter int unsigned DIV_B = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  input  logic sel_b_i,
  output logic hit_o
);
  localparam int unsigned CW = $clog2(DIV_B);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;

  assign limit = sel_b_i ? CW'(DIV_B - 1) : CW'(DIV_A - 1);
  assign hit_o = tick_i && (cnt_q == limit);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= (cnt_q == limit) ? '0 : cnt_q + 1'b1;
endmodule

// File: rtl/tmr_snap.sv
module tmr_snap
  import snap_pkg::*;
#(
  parameter int unsigned TW          = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DIV_A       = 4,
  parameter int unsigned DIV_B       = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pin_i,
  input  logic [TW-1:0] tmr_i,
  input  logic [3:0]    mode_i,
  input  logic          flag_clr_i,
  output logic [TW-1:0] cap_o,
  output logic          flag_o
);
  logic            rise, fall, div_hit, div_clr, tick;
  logic            off, mode_chg, ev;
  logic            hit_q, flag_q;
  logic [3:0]      mode_q;
  logic [TW-1:0]   cap_q;

  snap_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  assign off      = (mode_i == MD_OFF);
  assign mode_chg = (mode_i != mode_q);
  assign div_clr  = off | mode_chg;
  assign tick     = rise & ~div_clr &
                    ((mode_i == MD_RISE4) | (mode_i == MD_RISE16));

  snap_div #(.DIV_A(DIV_A), .DIV_B(DIV_B)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (div_clr),
    .tick_i  (tick),
    .sel_b_i (mode_i == MD_RISE16),
    .hit_o   (div_hit)
  );

  always_comb begin
    ev = 1'b0;
    if (!div_clr) begin
      case (mode_i)
        MD_FALL:            ev = fall;
        MD_RISE:            ev = rise;
        MD_RISE4, MD_RISE16: ev = div_hit;
        default:            ev = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      mode_q <= MD_OFF;
      hit_q  <= 1'b0;
    end else begin
      mode_q <= mode_i;
      hit_q  <= ev;
    end

  // off wins over a pending event; capture wins over clear
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      cap_q  <= '0;
      flag_q <= 1'b0;
    end else if (off) begin
      cap_q  <= '0;
      flag_q <= 1'b0;
    end else if (hit_q) begin
      cap_q  <= tmr_i;
      flag_q <= 1'b1;
    end else if (flag_clr_i) begin
      flag_q <= 1'b0;
    end

  assign cap_o  = cap_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/snap_chk.sv
module snap_chk #(
  parameter int unsigned TW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [TW-1:0] tmr_i,
  input logic [3:0]    mode_i,
  input logic          flag_clr_i,
  input logic [TW-1:0] cap_o,
  input logic          flag_o,
  input logic          hit_i
);
  a_r1_off_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 4'b0000 |=> (cap_o == '0) && !flag_o);

  a_r2_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i && mode_i != 4'b0000 |=> (cap_o == $past(tmr_i)) && flag_o);

  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_i && mode_i != 4'b0000 |=> $stable(cap_o));

  a_r6_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o && !flag_clr_i && mode_i != 4'b0000 |=> flag_o);

  a_r7_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_clr_i && !hit_i && mode_i != 4'b0000 |=> !flag_o);

  a_r7_capture_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_clr_i && hit_i && mode_i != 4'b0000 |=> flag_o);
endmodule

bind tmr_snap snap_chk #(.TW(TW)) u_snap_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tmr_i      (tmr_i),
  .mode_i     (mode_i),
  .flag_clr_i (flag_clr_i),
  .cap_o      (cap_o),
  .flag_o     (flag_o),
  .hit_i      (hit_q)
);

// File: tb/tmr_snap_test.sv
module tmr_snap_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pin_i = 1'b0;
  logic [15:0] tmr_i = 16'h1000;
  logic [3:0]  mode_i = 4'b0000;
  logic        flag_clr_i = 1'b0;
  logic [15:0] cap_o;
  logic        flag_o;

  int    checks = 0;
  int    errors = 0;
  string req = "R10";
  bit    done = 0;

  // reference model state
  bit          hist[$] = '{0, 0, 0};
  bit          pend = 0;
  int          cnt = 0;
  logic [3:0]  pmode = 4'b0000;
  logic [15:0] ecap = 16'h0;
  bit          eflag = 0;

  always #2.5 clk_i = ~clk_i;

  tmr_snap uut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_i      (pin_i),
    .tmr_i      (tmr_i),
    .mode_i     (mode_i),
    .flag_clr_i (flag_clr_i),
    .cap_o      (cap_o),
    .flag_o     (flag_o)
  );

  task automatic compare();
    checks++;
    if (cap_o !== ecap || flag_o !== eflag) begin
      errors++;
      $display("FAIL %s: cap=%h flag=%b expected cap=%h flag=%b at %0t",
               req, cap_o, flag_o, ecap, eflag, $time);
    end
  endtask

  task automatic model();
    bit r, f, np;
    int lim;
    r = hist[1] & ~hist[0];
    f = ~hist[1] & hist[0];
    if (mode_i == 4'b0000) begin
      ecap = 16'h0; eflag = 0;
    end else if (pend) begin
      ecap = tmr_i; eflag = 1;
    end else if (flag_clr_i) begin
      eflag = 0;
    end
    np = 0;
    if (mode_i == 4'b0000 || mode_i != pmode) cnt = 0;
    else case (mode_i)
      4'b0100: np = f;
      4'b0101: np = r;
      4'b0110, 4'b0111: if (r) begin
        lim = (mode_i == 4'b0110) ? 3 : 15;
        if (cnt == lim) begin cnt = 0; np = 1; end
        else cnt++;
      end
      default: np = 0;
    endcase
    pend = np;
    pmode = mode_i;
    hist.push_back(pin_i);
    void'(hist.pop_front());
  endtask

  task automatic step();
    @(posedge clk_i);
    model();
    @(negedge clk_i);
    compare();
    tmr_i = tmr_i + 16'd7;
  endtask

  task automatic pulses(int n, int hi, int lo);
    for (int i = 0; i < n; i++) begin
      pin_i = 1'b1;
      repeat (hi) step();
      pin_i = 1'b0;
      repeat (lo) step();
    end
  endtask

  task automatic idle(int n);
    repeat (n) step();
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    req = "R10";
    compare();
    rst_ni = 1'b1;
    idle(2);

    req = "R3 rise"; mode_i = 4'b0101;
    idle(2); pulses(3, 3, 6);
    req = "R2 latency"; pulses(1, 1, 8);
    req = "R3 fall"; mode_i = 4'b0100;
    idle(2); pulses(3, 4, 5);

    req = "R7 clear"; flag_clr_i = 1'b1; idle(2); flag_clr_i = 1'b0;
    req = "R6 sticky"; idle(10);
    req = "R5 overwrite"; mode_i = 4'b0101; idle(1); pulses(2, 2, 7);

    req = "R4 div4"; mode_i = 4'b0110; idle(2);
    flag_clr_i = 1'b1; idle(1); flag_clr_i = 1'b0;
    pulses(9, 2, 3);
    req = "R4 div16"; mode_i = 4'b0111; idle(2); pulses(35, 2, 2);

    req = "R8 mode change"; mode_i = 4'b0110; idle(2); pulses(2, 2, 3);
    mode_i = 4'b0111; idle(2); mode_i = 4'b0110; idle(2);
    pulses(5, 2, 3);
    req = "R8 same-cycle"; mode_i = 4'b0101; pin_i = 1'b1; idle(1);
    mode_i = 4'b0100; idle(1); mode_i = 4'b0101; idle(1);
    pin_i = 1'b0; idle(6);

    req = "R7 capture wins"; flag_clr_i = 1'b1; pulses(4, 1, 4); idle(4);
    flag_clr_i = 1'b0;

    req = "R9 unused code"; pulses(1, 2, 6); mode_i = 4'b1010; idle(2);
    pulses(4, 2, 3); mode_i = 4'b0010; pulses(3, 2, 3);
    flag_clr_i = 1'b1; idle(1); flag_clr_i = 1'b0; idle(3);

    req = "R1 off"; mode_i = 4'b0111; idle(2); pulses(5, 2, 2);
    mode_i = 4'b0101; pulses(1, 2, 1); mode_i = 4'b0000; idle(4);
    mode_i = 4'b0111; idle(1); pulses(17, 2, 2);
    req = "R1 off div"; mode_i = 4'b0110; idle(2); pulses(2, 2, 2);
    mode_i = 4'b0000; idle(2); mode_i = 4'b0110; idle(2); pulses(4, 2, 2);
    idle(6);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule